// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital front end of a four-channel digital-to-analog converter. A host writes a serial word framed by an active-low chip select. The word is shifted in most significant bit first, and the block decodes it when chip select rises again. Depending on its two command bits, the word does one of three things:

- it writes a data code into the input register of one channel;
- it shuts down one channel;
- it shuts down all channels.

An active-low load strobe moves the four input registers into the four DAC registers that feed the converters. While the strobe is low the DAC registers follow the input registers. While it is high they hold their values. This double buffering lets the host update all four channels at the same moment. The outputs are four DAC codes and four shutdown flags.

All pin-level inputs (serial clock, chip select, serial data and load strobe) are synchronized into the system clock domain. Edges are detected there, so the serial clock must have a period of at least four system clocks. The parameter `DATA_W` sets the data field width: 12 gives a 16-bit word and 10 gives a 14-bit word. An asynchronous active-low reset clears the input registers, the DAC registers and the shutdown flags. It leaves the serial shift register untouched.

Top module: `qdac_serial_if`

## Requirements
- R1: On each rising serial-clock edge seen while chip select is low, the shift register takes one serial data bit, MSB first. A word is WORD_W = DATA_W+4 bits: bit WORD_W-1 is the all-off command, bit WORD_W-2 is the channel-off command, bits WORD_W-3:WORD_W-4 are the channel address (0=A, 1=B, 2=C, 3=D), and bits DATA_W-1:0 are the data code.
- R2: Serial clock edges and serial data seen while chip select is high have no effect on the shift register.
- R3: A rising edge of chip select decodes the shift register. The word used is the last WORD_W bits shifted in, whether the frame had fewer, exactly WORD_W, or more clocks.
- R4: A decoded word whose all-off bit is 1 sets all four shutdown flags, whatever its other bits hold.
- R5: A decoded word with all-off bit 0 and channel-off bit 1 sets only the shutdown flag of the addressed channel and changes no input register.
- R6: A decoded word with both command bits 0 writes its data code into the addressed input register and clears that channel's shutdown flag.
- R7: While the load strobe is low, each DAC register takes its input register value on every system clock.
- R8: While the load strobe is high, the DAC registers hold. Rising of the strobe latches the values present at that time.
- R9: Reset drives all input registers, DAC registers and shutdown flags to zero and leaves the shift register contents unchanged.
- R10: Each DAC code output shows its DAC register whatever the channel's shutdown flag, so the code is kept through shutdown and is present again on wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock pin, asynchronous |
| csNIn | input | 1 | Active-low chip select pin, asynchronous |
| sdiIn | input | 1 | Serial data pin, asynchronous |
| loadNIn | input | 1 | Active-low level-sensitive load strobe, asynchronous |
| dacCode | output | 4*DATA_W | DAC register codes, channel A in the lowest DATA_W bits |
| shutdown | output | 4 | Per-channel shutdown flags, bit 0 = channel A |

## Verification
Some properties can be checked on every cycle. The shift register holds when no shift strobe arrives. The DAC registers either track the input registers or hold, according to the synchronized strobe level. After each decoded command, the shutdown flags show the correct global or per-channel state. Other behaviour only shows in the bench's scenarios, because it spans whole frames or external events:

- MSB-first assembly, through the vector table;
- frames that are too short or too long, and back-to-back frames;
- the shift register surviving a reset together with clocks applied while chip select is high;
- codes kept through shutdown.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int ADDR_W = 2;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
    logic loadOpen;
  } ctrlStrb_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= {STAGES{RST_VAL}};
    else       stg <= {stg[STAGES-2:0], din};
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclkIn,
  input  logic      csNIn,
  input  logic      sdiIn,
  input  logic      loadNIn,
  output ctrlStrb_t strb
);
  // lane order: 0 serial clock, 1 chip select, 2 data, 3 load strobe
  localparam int         N_LANES  = 4;
  localparam logic [3:0] RST_VALS = 4'b1010;

  logic [N_LANES-1:0] rawIn;
  logic [N_LANES-1:0] syncIn;
  logic               sclkPrev;
  logic               csPrev;

  assign rawIn = {loadNIn, sdiIn, csNIn, sclkIn};

  for (genvar g = 0; g < N_LANES; g++) begin : gLane
    qdac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_VALS[g])) uSync (
      .clk (clk),
      .rstN(rstN),
      .din (rawIn[g]),
      .dout(syncIn[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= syncIn[0];
      csPrev   <= syncIn[1];
    end
  end

  always_comb begin
    strb.shiftEn  = syncIn[0] & ~sclkPrev & ~syncIn[1];
    strb.shiftBit = syncIn[2];
    strb.commit   = syncIn[1] & ~csPrev;
    strb.loadOpen = ~syncIn[3];
  end

  AST_COMMIT_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit); // R3
endmodule

// File: rtl/qdac_dp.sv
module qdac_dp
  import qdac_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  output logic [4*DATA_W-1:0]      dacCode,
  output logic [(1<<ADDR_W)-1:0]   shutdown
);
  localparam int NUM_CH = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + ADDR_W + 2;
  localparam int SA_POS = WORD_W - 1;
  localparam int SD_POS = WORD_W - 2;
  localparam int AD_TOP = WORD_W - 3;

  logic [WORD_W-1:0] shiftReg;
  logic              saBit;
  logic              sdBit;
  logic [ADDR_W-1:0] addrSel;
  logic [DATA_W-1:0] wordData;
  logic [NUM_CH-1:0] sdFlag;
  logic [DATA_W-1:0] inReg  [NUM_CH];
  logic [DATA_W-1:0] dacReg [NUM_CH];

  // shift register is deliberately outside the reset
  always_ff @(posedge clk) begin
    if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strb.shiftBit};
  end

  assign saBit    = shiftReg[SA_POS];
  assign sdBit    = shiftReg[SD_POS];
  assign addrSel  = shiftReg[AD_TOP -: ADDR_W];
  assign wordData = shiftReg[DATA_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    logic hit;
    assign hit = (addrSel == ADDR_W'(ch));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     inReg[ch] <= '0;
      else if (strb.commit && !saBit && !sdBit && hit) inReg[ch] <= wordData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              dacReg[ch] <= '0;
      else if (strb.loadOpen) dacReg[ch] <= inReg[ch];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sdFlag[ch] <= 1'b0;
      else if (strb.commit) begin
        if (saBit)      sdFlag[ch] <= 1'b1;
        else if (hit)   sdFlag[ch] <= sdBit;
      end
    end

    assign dacCode[ch*DATA_W +: DATA_W] = dacReg[ch];

    AST_DAC_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
      strb.loadOpen |=> (dacReg[ch] == $past(inReg[ch]))); // R7
    AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadOpen |=> $stable(dacReg[ch])); // R8
  end

  assign shutdown = sdFlag;

  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(shiftReg)); // R2
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && saBit) |=> (&sdFlag)); // R4
  AST_ONE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !saBit && sdBit) |=> sdFlag[$past(addrSel)]); // R5
  AST_WRITE_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !saBit && !sdBit) |=> !sdFlag[$past(addrSel)]); // R6
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
  import qdac_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclkIn,
  input  logic                    csNIn,
  input  logic                    sdiIn,
  input  logic                    loadNIn,
  output logic [4*DATA_W-1:0]     dacCode,
  output logic [3:0]              shutdown
);
  ctrlStrb_t strb;

  qdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclkIn (sclkIn),
    .csNIn  (csNIn),
    .sdiIn  (sdiIn),
    .loadNIn(loadNIn),
    .strb   (strb)
  );

  qdac_dp #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dacCode (dacCode),
    .shutdown(shutdown)
  );
endmodule

// File: tb/qdac_serial_if_test.sv
module qdac_serial_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int N_VEC = 9;

  // {word[15:0], A, B, C, D (12 bits each), shutdown[3:0]}
  localparam logic [67:0] VEC [N_VEC] = '{
    68'h0123_123_000_000_000_0,
    68'h1ABC_123_ABC_000_000_0,
    68'h2FFF_123_ABC_FFF_000_0,
    68'h3800_123_ABC_FFF_800_0,
    68'h6000_123_ABC_FFF_800_4,
    68'h8000_123_ABC_FFF_800_F,
    68'h1555_123_555_FFF_800_D,
    68'hC000_123_555_FFF_800_F,
    68'h0000_000_555_FFF_800_E
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0;
  logic csNIn = 1'b1;
  logic sdiIn = 1'b0;
  logic loadNIn = 1'b0;
  logic [4*DW-1:0] dacCode;
  logic [3:0] shutdown;
  int nChecks = 0;
  int nFail = 0;

  qdac_serial_if #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn),
    .sdiIn(sdiIn), .loadNIn(loadNIn), .dacCode(dacCode), .shutdown(shutdown)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] code(input int ch);
    return dacCode[ch*DW +: DW];
  endfunction

  task automatic sendBits(input logic [31:0] bits, input int n, input int gap);
    csNIn = 1'b0;
    waitCyc(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdiIn = bits[i];
      sclkIn = 1'b0;
      waitCyc(4);
      sclkIn = 1'b1;
      waitCyc(4);
    end
    sclkIn = 1'b0;
    waitCyc(4);
    csNIn = 1'b1;
    waitCyc(gap);
  endtask

  task automatic chkAll(input string req, input logic [47:0] codes, input logic [3:0] sd);
    @(negedge clk);
    chk(req, 32'(code(0)), 32'(codes[47:36]));
    chk(req, 32'(code(1)), 32'(codes[35:24]));
    chk(req, 32'(code(2)), 32'(codes[23:12]));
    chk(req, 32'(code(3)), 32'(codes[11:0]));
    chk(req, 32'(shutdown), 32'(sd));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog (all R): actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    waitCyc(5);
    chkAll("R9 power-on reset", 48'h0, 4'h0);
    rstN = 1'b1;
    waitCyc(5);

    // R1 R4 R5 R6 R10: vector table, load strobe held low
    for (int v = 0; v < N_VEC; v++) begin
      sendBits(32'(VEC[v][67:52]), 16, 10);
      chkAll("R1/R4/R5/R6/R10 table", VEC[v][51:4], VEC[v][3:0]);
    end

    // R8 hold while load high, R7 transparency when low
    loadNIn = 1'b1;
    waitCyc(6);
    sendBits(32'h0777, 16, 10);
    @(negedge clk); chk("R8 hold", 32'(code(0)), 32'h000);
    loadNIn = 1'b0;
    waitCyc(6);
    @(negedge clk); chk("R7 transparent", 32'(code(0)), 32'h777);
    loadNIn = 1'b1;
    waitCyc(6);
    sendBits(32'h0111, 16, 10);
    @(negedge clk); chk("R8 latched", 32'(code(0)), 32'h777);
    loadNIn = 1'b0;
    waitCyc(6);
    @(negedge clk); chk("R7 follow", 32'(code(0)), 32'h111);

    // R9 reset keeps shift register, R2 clocks with chip select high ignored
    sendBits(32'h02AA, 16, 10);
    @(negedge clk); chk("R6 write A", 32'(code(0)), 32'h2AA);
    rstN = 1'b0;
    waitCyc(3);
    chkAll("R9 reset clears", 48'h0, 4'h0);
    rstN = 1'b1;
    waitCyc(5);
    sdiIn = 1'b1;
    for (int k = 0; k < 16; k++) begin
      sclkIn = 1'b1; waitCyc(4);
      sclkIn = 1'b0; waitCyc(4);
    end
    csNIn = 1'b0; waitCyc(6);
    csNIn = 1'b1; waitCyc(10);
    chkAll("R2/R9 shift reg retained", 48'h2AA_000_000_000, 4'h0);

    // R3 short and long frames
    sendBits(32'h1234, 16, 10);
    sendBits(32'h56, 8, 10);
    sendBits(32'hF2345, 20, 10);
    chkAll("R3 short/long frames", 48'h2AA_234_345_456, 4'h0);

    // R3 back-to-back frames with minimal gap
    sendBits(32'h0A5A, 16, 4);
    sendBits(32'h15A5, 16, 10);
    chkAll("R3 back-to-back", 48'hA5A_5A5_345_456, 4'h0);

    // R5 single-channel shutdown keeps code (R10), R6 write wakes it
    sendBits(32'h7000, 16, 10);
    chkAll("R5/R10 D off", 48'hA5A_5A5_345_456, 4'h8);
    sendBits(32'h3ABC, 16, 10);
    chkAll("R6 D wake", 48'hA5A_5A5_345_ABC, 4'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule